// File: doc/BRIEF.md
# Vectored IRQ Priority Slot Resolver

This block sits behind the interrupt masking logic of a processor subsystem. It takes the 32-bit IRQ status vector (requests that are already enabled and routed to the normal interrupt class) and drives a single IRQ line to the processor. It holds sixteen programmable vector slots. Each slot has a control word that picks one of the 32 sources and enables the slot, and a 32-bit handler address. A default handler address serves every source that no enabled slot claims.

When the handler entry code reads the vector register, the block returns the handler address of the highest-priority active slot, or the default address if no slot qualifies. It then marks that priority level as in service. While a level is in service, only strictly higher-priority slots can raise the IRQ line or win a vector read. A write of any value to the vector register acknowledges the handler and retires the most recent in-service level. Nested handlers therefore stack naturally.

The register port is a simple single-cycle strobe interface with no back-pressure: every access completes in the cycle of its strobe, and read data appears on the following cycle. Since nothing streams through the block, it has no valid/ready pair. A read and a write must not be strobed in the same cycle.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset every slot address, slot control and the default address read as zero, the in-service state is empty, `irq_out` is low, and a vector read returns zero.
- R2: Byte offsets decode as follows. The vector register is at 0x030 and the default address at 0x034. Slot n handler address is at 0x100 + 4n and slot n control at 0x200 + 4n. In a control word, bits 4:0 select the source, bit 5 enables the slot, and bits 31:6 are not stored and read as zero.
- R3: A read strobe latches its result into `reg_rdata`, which holds it from the following cycle. A vector read returns the handler address of the winning active slot. A slot is active when it is enabled and its selected source bit in `irq_status` is 1.
- R4: When several slots are active, the lowest-numbered one wins.
- R5: When one source is selected by several enabled slots, the lowest-numbered of those slots is the one reported.
- R6: A source that no enabled slot selects still raises `irq_out`, and a vector read that finds no eligible slot returns the default address.
- R7: `irq_out` is registered. With nothing in service, it is high in the cycle after any `irq_status` bit is 1, and low in the cycle after `irq_status` is all zero.
- R8: A vector read pushes the winner's level onto the in-service state: slot n gives level n, and a default-address read gives level 16, below every slot. While a level is in service, only slots with a strictly lower number are eligible to win a vector read or to raise `irq_out`. Sources that no enabled slot selects are held off while any level is in service.
- R9: A write to the vector register stores nothing, so the written data never appears in a later read. It retires the highest-priority level in service, which is the most recently pushed one. Two nested acknowledges restore the state that existed before both reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_status | input | 32 | Enabled, IRQ-class request bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The slots are programmed with one source per slot, one source shared by two slots, and one slot left disabled. A single request shows the basic address lookup. A pair of requests on different slots separates fixed priority from arrival order. The shared source shows whether the duplicate tie breaks toward the lower slot. The disabled-slot source and an all-zero status both show the default path, with and without the IRQ line. A nested sequence then raises and drops requests above, at and below the in-service level, and acknowledges with a nonzero data word. This tells apart masking that is strict from masking that is inclusive, and a pop of the latest level from a pop of the oldest.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_VECTOR  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DEFAULT = 12'h034;
  localparam logic [3:0] PAGE_SLOT_ADDR = 4'h1;
  localparam logic [3:0] PAGE_SLOT_CTRL = 4'h2;
endpackage

// File: rtl/irqv_slot_regs.sv
module irqv_slot_regs
  import irqv_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SRC_W     = 5,
  parameter int DATA_W    = 32,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic                                  rd_en,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wdata,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]      slot_addr,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0]       slot_src,
  output logic [NUM_SLOTS-1:0]                  slot_en,
  output logic [DATA_W-1:0]                     def_addr,
  output logic [DATA_W-1:0]                     cfg_rdata
);
  logic [SLOT_W-1:0] idx;
  logic in_page, hit_addr, hit_ctrl, hit_def;

  assign idx      = addr[2 +: SLOT_W];
  assign in_page  = ((addr[7:2] >> SLOT_W) == 6'd0);
  assign hit_addr = in_page && (addr[11:8] == PAGE_SLOT_ADDR);
  assign hit_ctrl = in_page && (addr[11:8] == PAGE_SLOT_CTRL);
  assign hit_def  = (addr == OFS_DEFAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) def_addr <= '0;
    else if (wr_en && hit_def) def_addr <= wdata;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_addr[s] <= '0;
        slot_src[s]  <= '0;
        slot_en[s]   <= 1'b0;
      end else if (wr_en && idx == SLOT_W'(s)) begin
        if (hit_addr) slot_addr[s] <= wdata;
        if (hit_ctrl) begin
          slot_src[s] <= wdata[SRC_W-1:0];
          slot_en[s]  <= wdata[SRC_W];
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (rd_en) begin
      if (hit_def)       cfg_rdata = def_addr;
      else if (hit_addr) cfg_rdata = slot_addr[idx];
      else if (hit_ctrl) cfg_rdata = {{(DATA_W-SRC_W-1){1'b0}}, slot_en[idx], slot_src[idx]};
    end
  end
endmodule

// File: rtl/irqv_resolver.sv
module irqv_resolver #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic [NUM_SRC-1:0]               irq_status,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0]  slot_src,
  input  logic [NUM_SLOTS-1:0]             slot_en,
  input  logic [LVL_W-1:0]                 cur_level,
  output logic                             win_valid,
  output logic [SLOT_W-1:0]                win_idx,
  output logic                             nonvec_pend
);
  logic [NUM_SLOTS-1:0] active, eligible;
  logic [NUM_SRC-1:0]   claimed;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_act
    assign active[s]   = slot_en[s] && irq_status[slot_src[s]];
    assign eligible[s] = active[s] && (LVL_W'(s) < cur_level);
  end

  always_comb begin
    claimed = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slot_en[s]) claimed[slot_src[s]] = 1'b1;
  end

  assign nonvec_pend = |(irq_status & ~claimed);

  // Fixed priority: scan from the lowest priority so the lowest index is kept.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (eligible[s]) begin
        win_valid = 1'b1;
        win_idx   = SLOT_W'(s);
      end
    end
  end
endmodule

// File: rtl/irqv_inservice.sv
module irqv_inservice #(
  parameter int NUM_SLOTS = 16,
  localparam int NUM_LVL  = NUM_SLOTS + 1,
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [LVL_W-1:0]   push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] mask,
  output logic [LVL_W-1:0]   cur_level
);
  // Nesting only ever pushes a level above all held ones, so the most recent
  // entry is always the lowest set bit.
  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (pop)  mask <= mask & (mask - NUM_LVL'(1));
    else if (push) mask <= mask | (NUM_LVL'(1) << push_lvl);
  end

  always_comb begin
    cur_level = LVL_W'(NUM_LVL);
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (mask[l]) cur_level = LVL_W'(l);
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqv_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_status,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_out
);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int SLOT_W  = $clog2(NUM_SLOTS);
  localparam int NUM_LVL = NUM_SLOTS + 1;
  localparam int LVL_W   = $clog2(NUM_SLOTS + 2);

  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][SRC_W-1:0]  slot_src;
  logic [NUM_SLOTS-1:0]             slot_en;
  logic [DATA_W-1:0]                def_addr, cfg_rdata, vec_value;
  logic [NUM_LVL-1:0]               mask;
  logic [LVL_W-1:0]                 cur_level, push_lvl;
  logic [SLOT_W-1:0]                win_idx;
  logic                             win_valid, nonvec_pend;
  logic                             vec_hit, vec_read, vec_ack;

  assign vec_hit  = (reg_addr == OFS_VECTOR);
  assign vec_read = reg_rd && vec_hit;
  assign vec_ack  = reg_wr && vec_hit;

  irqv_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && !vec_hit), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata), .slot_addr(slot_addr),
    .slot_src(slot_src), .slot_en(slot_en), .def_addr(def_addr), .cfg_rdata(cfg_rdata)
  );

  irqv_resolver #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_pick (
    .irq_status(irq_status), .slot_src(slot_src), .slot_en(slot_en),
    .cur_level(cur_level), .win_valid(win_valid), .win_idx(win_idx),
    .nonvec_pend(nonvec_pend)
  );

  assign push_lvl = win_valid ? LVL_W'(win_idx) : LVL_W'(NUM_SLOTS);

  irqv_inservice #(.NUM_SLOTS(NUM_SLOTS)) u_isr (
    .clk(clk), .rst_n(rst_n), .push(vec_read), .push_lvl(push_lvl),
    .pop(vec_ack), .mask(mask), .cur_level(cur_level)
  );

  assign vec_value = win_valid ? slot_addr[win_idx] : def_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= vec_hit ? vec_value : cfg_rdata;
      irq_out <= win_valid || (nonvec_pend && cur_level == LVL_W'(NUM_LVL));
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int LVL_W    = $clog2(NUM_SLOTS + 2)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            reg_rd,
  input logic                            reg_wr,
  input logic                            vec_hit,
  input logic [NUM_SRC-1:0]              irq_status,
  input logic                            irq_out,
  input logic [NUM_SLOTS:0]              mask,
  input logic                            win_valid,
  input logic [SLOT_W-1:0]               win_idx,
  input logic [LVL_W-1:0]                cur_level,
  input logic [NUM_SLOTS-1:0]            slot_en,
  input logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_src
);
  AST_IRQ_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status == '0 |=> !irq_out); // R7
  AST_WINNER_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (slot_en[win_idx] && irq_status[slot_src[win_idx]])); // R3
  AST_WINNER_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (LVL_W'(win_idx) < cur_level)); // R8
  AST_READ_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && vec_hit) |=> mask != '0); // R8
  AST_ACK_POPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && vec_hit && mask != '0) |=> $countones(mask) == $past($countones(mask)) - 1); // R9
  AST_NO_RD_WR_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R3
endmodule

bind irq_vector_arbiter irqv_checker #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr), .vec_hit(vec_hit),
  .irq_status(irq_status), .irq_out(irq_out), .mask(mask), .win_valid(win_valid),
  .win_idx(win_idx), .cur_level(cur_level), .slot_en(slot_en), .slot_src(slot_src)
);

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_status = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int checks = 0, errors = 0;

  localparam logic [31:0] DEF_VA = 32'h0DEF_0000;

  always #4 clk = ~clk;

  irq_vector_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_status(irq_status), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [31:0] slot_va(int n);
    return 32'hA000_0000 | (n << 4);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_status(logic [31:0] v);
    @(negedge clk); irq_status = v;
    settle();
  endtask

  task automatic vec_case(string req, logic [31:0] st, logic [31:0] exp_va, logic exp_irq);
    logic [31:0] d;
    set_status(st);
    check({req, " irq"}, 32'(irq_out), 32'(exp_irq));
    rd(12'h030, d);
    check({req, " vector"}, d, exp_va);
    wr(12'h030, 32'h0);
    set_status(32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_out), 32'h0);
    rd(12'h034, d); check("R1 default", d, 32'h0);
    rd(12'h108, d); check("R1 slot addr", d, 32'h0);
    rd(12'h23C, d); check("R1 slot ctrl", d, 32'h0);
    rd(12'h030, d); check("R1 vector", d, 32'h0);
    wr(12'h030, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(12'h034, DEF_VA);
    for (int n = 0; n < 16; n++) wr(12'h100 + 12'(4 * n), slot_va(n));
    wr(12'h20C, 32'hFFFF_FFE7);
    rd(12'h20C, d); check("R2 ctrl reserved", d, 32'h0000_0027);
    rd(12'h10C, d); check("R2 slot3 addr", d, slot_va(3));
    rd(12'h034, d); check("R2 default", d, DEF_VA);
    wr(12'h200, 32'h24);  // slot0: source 4, enabled
    wr(12'h204, 32'h29);  // slot1: source 9
    wr(12'h208, 32'h29);  // slot2: source 9 (duplicate)
    wr(12'h20C, 32'h14);  // slot3: source 20, disabled
    wr(12'h214, 32'h27);  // slot5: source 7
    rd(12'h20C, d); check("R2 ctrl disabled", d, 32'h14);
  endtask

  task automatic t_nested();
    logic [31:0] d;
    set_status(32'h80);
    rd(12'h030, d); check("R8 first read", d, slot_va(5));
    settle(); check("R8 same level held", 32'(irq_out), 32'h0);
    set_status(32'h0010_0080);
    check("R8 nonvectored held", 32'(irq_out), 32'h0);
    set_status(32'h0010_0280);
    check("R8 higher slot raises", 32'(irq_out), 32'h1);
    rd(12'h030, d); check("R8 nested read", d, slot_va(1));
    settle(); check("R8 lower held", 32'(irq_out), 32'h0);
    wr(12'h030, 32'h0000_1234);
    settle(); check("R9 pop latest", 32'(irq_out), 32'h1);
    set_status(32'h0010_0080);
    check("R9 level5 still held", 32'(irq_out), 32'h0);
    wr(12'h030, 32'hFFFF_FFFF);
    settle(); check("R9 all popped", 32'(irq_out), 32'h1);
    rd(12'h030, d); check("R9 write not stored", d, slot_va(5));
    wr(12'h030, 32'h0);
    set_status(32'h0);
    check("R7 idle low", 32'(irq_out), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    vec_case("R3 single", 32'h0000_0080, slot_va(5), 1'b1);
    vec_case("R4 priority", 32'h0000_0090, slot_va(0), 1'b1);
    vec_case("R5 duplicate", 32'h0000_0200, slot_va(1), 1'b1);
    vec_case("R6 disabled slot", 32'h0010_0000, DEF_VA, 1'b1);
    vec_case("R7 none pending", 32'h0, DEF_VA, 1'b0);
    t_nested();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule